// File: doc/BRIEF.md
# Multi-phase serial frame receiver

This block takes a serial bit stream that is qualified by a bit-clock enable and delimited by a frame-sync level. It cuts the stream into elements and hands each finished element to a host as a right-justified 32-bit word. A frame has one or two phases. Each phase has its own element count and its own element length. The first data bit may lag the frame-sync edge by zero, one or two bit clocks.

Received bits pass through three stages: a shift register, a holding buffer and the host-visible data register. This gives the host close to two element times to fetch a word before anything is lost. When a word is lost anyway, an overrun flag reports it.

A frame-sync edge that arrives in the middle of a frame is either treated as a restart and flagged, or discarded, depending on a configuration input. An edge that lands exactly on the slot where the next frame must begin is always accepted, so frames can run back to back with no idle bit between them.

Top module: `serframe_rx`

## Requirements
- R1: The element length code selects 8, 12, 16, 20 or 24 bits for codes 0 to 4, and 32 bits for codes 5, 6 and 7. Bits arrive MSB first. A finished element appears in rdData right-justified, with the unused upper bits at zero.
- R2: With twoPhase low, a frame holds cnt1+1 elements of the phase-one length. After the last element the receiver is idle until the next frame-sync edge.
- R3: With twoPhase high, the cnt1+1 phase-one elements are followed, with no gap, by cnt2+1 elements of the phase-two length.
- R4: A frame-sync edge is an enabled cycle with fsIn high whose previous enabled cycle had fsIn low. The first data bit is sampled in that same enabled cycle for dataDelay 0, or 1 or 2 enabled cycles later for dataDelay 1 or 2. Code 3 acts as 2.
- R5: Cycles with bitEn low neither sample sdIn nor detect frame sync, whatever sdIn and fsIn do during them.
- R6: A finished element enters the buffer when the buffer is empty or is being emptied in the same cycle. The buffer moves into the data register whenever ready is low, and ready then rises. ready rises two clock cycles after the cycle that samples an element's last bit, when both stages were empty. A rdStrobe while ready is high clears ready on the next cycle. rdData does not change while ready is high.
- R7: An element that finishes while ready is high and the buffer is occupied sets full and is discarded. The data register and the buffer keep their contents. A rdStrobe while ready is high clears full.
- R8: With ignoreFs low, a frame-sync edge during a frame, other than at the boundary slot of R10, sets syncErr. syncErr stays set until reset. The edge discards the partial element and starts a new frame from that edge.
- R9: With ignoreFs high, such mid-frame edges have no effect: the frame completes unchanged and syncErr stays low.
- R10: For dataDelay d of 1 or 2, an edge that arrives d-1 enabled cycles before the frame's last data bit starts the next frame without error. For d of 0, an edge in the enabled cycle after the last bit does the same. Either way, frames can be packed back to back with no idle bit.
- R11: A synchronous reset clears ready, full, syncErr, rdData and all buffering, and returns framing to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bitEn | input | 1 | Bit-clock enable; serial state advances only when high |
| sdIn | input | 1 | Serial data bit |
| fsIn | input | 1 | Frame-sync level |
| rdStrobe | input | 1 | Host read strobe for the data register |
| twoPhase | input | 1 | Frame has a second phase |
| cnt1 | input | 7 | Phase-one element count minus one |
| cnt2 | input | 7 | Phase-two element count minus one |
| len1 | input | 3 | Phase-one element length code |
| len2 | input | 3 | Phase-two element length code |
| dataDelay | input | 2 | Bit clocks from frame-sync edge to first data bit |
| ignoreFs | input | 1 | Discard mid-frame frame-sync edges |
| rdData | output | 32 | Host-visible received word |
| ready | output | 1 | Data register holds an unread word |
| full | output | 1 | An element was lost to overrun |
| syncErr | output | 1 | An unexpected frame-sync edge was seen |

## Verification
The assertions assume that the configuration inputs stay constant while a frame is in progress. They also assume that the host strobes a read only as a single-cycle pulse. The stimulus changes length, count, delay and ignore settings only after the stream has ended and the receiver has idled for several cycles. Read pulses always last exactly one cycle. Frame-sync pulses are one enabled cycle wide and are placed at offsets computed from the element lengths, so an edge lands on the boundary slot or on a deliberate mid-frame slot, never by accident.

// File: rtl/serframe_pkg.sv
`timescale 1ns/1ps
package serframe_pkg;

  parameter int WORD_W = 32;
  parameter int LEN_W  = $clog2(WORD_W) + 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_DATA  = 2'd2
  } rxState_t;

  // strobes from framing control to the datapath, one cycle each
  typedef struct packed {
    logic shiftEn;     // take sdIn into the shift register
    logic shiftClr;    // this bit opens a new element
    logic elemDone;    // this bit closes the element
    logic syncErrSet;  // unexpected frame sync seen
  } rxCtl_t;

  function automatic logic [LEN_W-1:0] elemBits(input logic [2:0] code);
    case (code)
      3'd0:    return LEN_W'(8);
      3'd1:    return LEN_W'(12);
      3'd2:    return LEN_W'(16);
      3'd3:    return LEN_W'(20);
      3'd4:    return LEN_W'(24);
      default: return LEN_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/serframe_ctrl.sv
`timescale 1ns/1ps
module serframe_ctrl
  import serframe_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bitEn,
  input  logic             fsIn,
  input  logic             twoPhase,
  input  logic [CNT_W-1:0] cnt1,
  input  logic [CNT_W-1:0] cnt2,
  input  logic [2:0]       len1,
  input  logic [2:0]       len2,
  input  logic [1:0]       dataDelay,
  input  logic             ignoreFs,
  output rxCtl_t           ctl
);

  localparam int IDX_W = LEN_W - 1;

  rxState_t         state;
  logic [1:0]       dlyCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [CNT_W-1:0] elemIdx;
  logic             inPhase2;
  logic             pend;
  logic             fsPrev;

  logic [1:0]       effDly;
  logic [LEN_W-1:0] curLen;
  logic [CNT_W-1:0] curCnt;
  logic             fsEdge, busy, sampling, lastBit, lastElem;
  logic             frameLast, frameNextLast, boundary, unexpected, startNow;

  always_comb begin
    effDly        = (dataDelay == 2'd3) ? 2'd2 : dataDelay;
    curLen        = elemBits(inPhase2 ? len2 : len1);
    curCnt        = inPhase2 ? cnt2 : cnt1;
    fsEdge        = bitEn && fsIn && !fsPrev;
    busy          = (state != ST_IDLE);
    sampling      = bitEn && ((state == ST_DATA) ||
                              ((state == ST_DELAY) && (dlyCnt == 2'd0)));
    lastBit       = ({1'b0, bitIdx} == (curLen - LEN_W'(1)));
    lastElem      = (elemIdx == curCnt) && (inPhase2 || !twoPhase);
    frameLast     = sampling && lastBit && lastElem;
    frameNextLast = sampling && ({1'b0, bitIdx} == (curLen - LEN_W'(2))) && lastElem;
    boundary      = fsEdge && busy &&
                    (((effDly == 2'd1) && frameLast) ||
                     ((effDly == 2'd2) && frameNextLast));
    unexpected    = fsEdge && busy && !boundary && !ignoreFs;
    startNow      = fsEdge && (!busy || unexpected);
  end

  always_comb begin
    ctl = '0;
    if (startNow) begin
      ctl.syncErrSet = unexpected;
      if (effDly == 2'd0) begin
        ctl.shiftEn  = 1'b1;
        ctl.shiftClr = 1'b1;
      end
    end else if (sampling) begin
      ctl.shiftEn  = 1'b1;
      ctl.shiftClr = (bitIdx == '0);
      ctl.elemDone = lastBit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      dlyCnt   <= '0;
      bitIdx   <= '0;
      elemIdx  <= '0;
      inPhase2 <= 1'b0;
      pend     <= 1'b0;
      fsPrev   <= 1'b0;
    end else begin
      if (bitEn) fsPrev <= fsIn;
      if (startNow) begin
        inPhase2 <= 1'b0;
        elemIdx  <= '0;
        pend     <= 1'b0;
        if (effDly == 2'd0) begin
          state  <= ST_DATA;
          bitIdx <= IDX_W'(1);
        end else begin
          state  <= ST_DELAY;
          dlyCnt <= effDly - 2'd1;
          bitIdx <= '0;
        end
      end else if (sampling) begin
        state <= ST_DATA;
        if (boundary && (effDly == 2'd2)) pend <= 1'b1;
        if (lastBit) begin
          bitIdx <= '0;
          if (elemIdx == curCnt) begin
            elemIdx <= '0;
            if (!inPhase2 && twoPhase) begin
              inPhase2 <= 1'b1;
            end else begin
              inPhase2 <= 1'b0;
              if (pend || boundary) begin
                state  <= ST_DELAY;
                dlyCnt <= 2'd0;
                pend   <= 1'b0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end else begin
            elemIdx <= elemIdx + CNT_W'(1);
          end
        end else begin
          bitIdx <= bitIdx + IDX_W'(1);
        end
      end else if (bitEn && (state == ST_DELAY)) begin
        dlyCnt <= dlyCnt - 2'd1;
      end
    end
  end

endmodule

// File: rtl/serframe_dp.sv
`timescale 1ns/1ps
module serframe_dp
  import serframe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sdIn,
  input  logic              rdStrobe,
  input  rxCtl_t            ctl,
  output logic [WORD_W-1:0] rdData,
  output logic              ready,
  output logic              full,
  output logic              syncErr
);

  logic [WORD_W-2:0] shiftReg;
  logic [WORD_W-1:0] nextWord;
  logic [WORD_W-1:0] bufReg;
  logic [WORD_W-1:0] dataReg;
  logic              bufValid;
  logic              moveBuf, bufFree, accept, overrun;

  always_comb begin
    nextWord = ctl.shiftClr ? {{(WORD_W-1){1'b0}}, sdIn} : {shiftReg, sdIn};
    moveBuf  = bufValid && !ready;
    bufFree  = !bufValid || !ready;
    accept   = ctl.elemDone && bufFree;
    overrun  = ctl.elemDone && !bufFree;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      bufReg   <= '0;
      dataReg  <= '0;
      bufValid <= 1'b0;
      ready    <= 1'b0;
      full     <= 1'b0;
      syncErr  <= 1'b0;
    end else begin
      if (ctl.shiftEn) shiftReg <= nextWord[WORD_W-2:0];

      if (moveBuf) begin
        dataReg <= bufReg;
        ready   <= 1'b1;
      end else if (rdStrobe) begin
        ready <= 1'b0;
      end

      if (accept) begin
        bufReg   <= nextWord;
        bufValid <= 1'b1;
      end else if (moveBuf) begin
        bufValid <= 1'b0;
      end

      if (overrun)                full <= 1'b1;
      else if (rdStrobe && ready) full <= 1'b0;

      if (ctl.syncErrSet) syncErr <= 1'b1;
    end
  end

  assign rdData = dataReg;

endmodule

// File: rtl/serframe_rx.sv
`timescale 1ns/1ps
module serframe_rx
  import serframe_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitEn,
  input  logic              sdIn,
  input  logic              fsIn,
  input  logic              rdStrobe,
  input  logic              twoPhase,
  input  logic [CNT_W-1:0]  cnt1,
  input  logic [CNT_W-1:0]  cnt2,
  input  logic [2:0]        len1,
  input  logic [2:0]        len2,
  input  logic [1:0]        dataDelay,
  input  logic              ignoreFs,
  output logic [WORD_W-1:0] rdData,
  output logic              ready,
  output logic              full,
  output logic              syncErr
);

  rxCtl_t ctl;

  serframe_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bitEn     (bitEn),
    .fsIn      (fsIn),
    .twoPhase  (twoPhase),
    .cnt1      (cnt1),
    .cnt2      (cnt2),
    .len1      (len1),
    .len2      (len2),
    .dataDelay (dataDelay),
    .ignoreFs  (ignoreFs),
    .ctl       (ctl)
  );

  serframe_dp u_dp (
    .clk      (clk),
    .rst      (rst),
    .sdIn     (sdIn),
    .rdStrobe (rdStrobe),
    .ctl      (ctl),
    .rdData   (rdData),
    .ready    (ready),
    .full     (full),
    .syncErr  (syncErr)
  );

endmodule

// File: rtl/serframe_rx_chk.sv
`timescale 1ns/1ps
module serframe_rx_chk (
  input logic        clk,
  input logic        rst,
  input logic        bitEn,
  input logic        ignoreFs,
  input logic        rdStrobe,
  input logic        ready,
  input logic        full,
  input logic        syncErr,
  input logic [31:0] rdData,
  input logic        shiftEn
);

  // R5: no sampling without the bit-clock enable
  p_gated_shift_r5: assert property (@(posedge clk) disable iff (rst)
    shiftEn |-> bitEn);

  // R6: the host word holds while it is unread
  p_hold_data_r6: assert property (@(posedge clk) disable iff (rst)
    ready |=> $stable(rdData));

  // R6: a read drops ready
  p_read_drops_ready_r6: assert property (@(posedge clk) disable iff (rst)
    (ready && rdStrobe) |=> !ready);

  // R7: overrun only when the data register was occupied
  p_full_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> $past(ready));

  // R8: sync error is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    syncErr |=> syncErr);

  // R9: no sync error while edges are being ignored
  p_ignore_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(syncErr) |-> !$past(ignoreFs));

  // R11: reset leaves every flag and the word cleared
  p_reset_clear_r11: assert property (@(posedge clk)
    $past(rst) |-> (!ready && !full && !syncErr && (rdData == 32'd0)));

endmodule

bind serframe_rx serframe_rx_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bitEn    (bitEn),
  .ignoreFs (ignoreFs),
  .rdStrobe (rdStrobe),
  .ready    (ready),
  .full     (full),
  .syncErr  (syncErr),
  .rdData   (rdData),
  .shiftEn  (ctl.shiftEn)
);

// File: tb/serframe_rx_bench.sv
`timescale 1ns/1ps
module serframe_rx_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        bitEn = 1'b0, sdIn = 1'b0, fsIn = 1'b0;
  logic        autoRdS = 1'b0, manRdS = 1'b0;
  logic        rdStrobe;
  logic        twoPhase = 1'b0, ignoreFs = 1'b0;
  logic [6:0]  cnt1 = '0, cnt2 = '0;
  logic [2:0]  len1 = '0, len2 = '0;
  logic [1:0]  dataDelay = '0;
  logic [31:0] rdData;
  logic        ready, full, syncErr;

  assign rdStrobe = autoRdS | manRdS;

  int          total = 0, bad = 0, cyc = 0;
  logic [31:0] expQ[$];
  bit          autoRead = 1'b0;
  string       tag = "R1";
  logic        fsArr [0:4095];
  logic        sdArr [0:4095];
  int          streamLen = 0;
  int          gapCycles = 0;

  serframe_rx u_serframe_rx (
    .clk(clk), .rst(rst), .bitEn(bitEn), .sdIn(sdIn), .fsIn(fsIn),
    .rdStrobe(rdStrobe), .twoPhase(twoPhase), .cnt1(cnt1), .cnt2(cnt2),
    .len1(len1), .len2(len2), .dataDelay(dataDelay), .ignoreFs(ignoreFs),
    .rdData(rdData), .ready(ready), .full(full), .syncErr(syncErr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lenOf(logic [2:0] code);
    return (code <= 3'd4) ? 8 + 4 * int'(code) : 32;
  endfunction

  function automatic logic [31:0] elemVal(int seed, int i, int bits);
    logic [31:0] v;
    v = (32'(seed) * 32'h9E3779B1) ^ (32'(i + 1) * 32'h85EBCA6B) ^ 32'hA5C30F1E;
    return (bits == 32) ? v : (v & ((32'd1 << bits) - 32'd1));
  endfunction

  // host model: reads every word as soon as ready is seen
  always @(negedge clk) begin
    if (autoRdS) autoRdS = 1'b0;
    else if (autoRead && ready) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL %s extra word actual=%h expected=none", tag, rdData);
      end else begin
        check(tag, rdData, expQ.pop_front());
      end
      autoRdS = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic clearStream();
    for (int i = 0; i < 4096; i++) begin fsArr[i] = 1'b0; sdArr[i] = 1'b0; end
    streamLen = 0;
  endtask

  task automatic addFrame(int off, int seed, bit push, output int nBits);
    int d, k;
    d = (dataDelay == 2'd3) ? 2 : int'(dataDelay);
    k = 0;
    fsArr[off] = 1'b1;
    for (int ph = 0; ph < (twoPhase ? 2 : 1); ph++) begin
      int n;
      int bits;
      n    = int'(ph == 0 ? cnt1 : cnt2) + 1;
      bits = lenOf(ph == 0 ? len1 : len2);
      for (int e = 0; e < n; e++) begin
        logic [31:0] v;
        v = elemVal(seed, ph * 200 + e, bits);
        if (push) expQ.push_back(v);
        for (int b = bits - 1; b >= 0; b--) begin
          sdArr[off + d + k] = v[b];
          k++;
        end
      end
    end
    nBits = k;
    if (off + d + k > streamLen) streamLen = off + d + k;
  endtask

  task automatic play();
    for (int s = 0; s < streamLen; s++) begin
      @(negedge clk); bitEn = 1'b1; fsIn = fsArr[s]; sdIn = sdArr[s];
      for (int g = 0; g < gapCycles; g++) begin
        @(negedge clk); bitEn = 1'b0; fsIn = ~fsArr[s]; sdIn = ~sdArr[s];
      end
    end
    @(negedge clk); bitEn = 1'b0; fsIn = 1'b0; sdIn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic runPair(string t, int seed);
    int n1, n2;
    clearStream();
    addFrame(0, seed, 1'b1, n1);
    addFrame(n1, seed + 1, 1'b1, n2);   // boundary slot: back to back (R10)
    tag = t; autoRead = 1'b1;
    play();
    repeat (8) @(negedge clk);
    check({t, " word count"}, expQ.size(), 0);
    check("R10 back-to-back no sync error", {31'd0, syncErr}, 32'd0);
  endtask

  initial begin
    int n, n2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: state after reset
    check("R11 ready after reset", {31'd0, ready}, 0);
    check("R11 full after reset", {31'd0, full}, 0);
    check("R11 syncErr after reset", {31'd0, syncErr}, 0);
    check("R11 rdData after reset", rdData, 0);

    // R6: ready timing for a lone 8-bit element, delay 0
    autoRead = 1'b0; twoPhase = 1'b0; len1 = 3'd0; cnt1 = 7'd0; dataDelay = 2'd0;
    clearStream(); addFrame(0, 77, 1'b0, n);
    play();
    check("R6 ready still low one cycle after last bit", {31'd0, ready}, 0);
    @(negedge clk);
    check("R6 ready two cycles after last bit", {31'd0, ready}, 1);
    check("R6 R1 word value", rdData, elemVal(77, 0, 8));
    manRdS = 1'b1; @(negedge clk); manRdS = 1'b0;
    check("R6 read clears ready", {31'd0, ready}, 0);
    repeat (3) @(negedge clk);

    // R1 R2 R4 R10: single-phase sweep over lengths and delays
    for (int lc = 0; lc < 8; lc++) begin
      for (int d = 0; d < 4; d++) begin
        twoPhase = 1'b0; len1 = 3'(lc); cnt1 = 7'(lc % 3);
        dataDelay = 2'(d); ignoreFs = d[0];
        runPair("R1 R2 R4 single", lc * 10 + d);
      end
    end

    // R1 R3 R4 R10: two-phase sweep
    for (int lc = 0; lc < 8; lc++) begin
      for (int d = 0; d < 4; d++) begin
        twoPhase = 1'b1; len1 = 3'(lc); len2 = 3'((lc + 3) % 8);
        cnt1 = 7'(lc % 2); cnt2 = 7'(1 + lc % 2);
        dataDelay = 2'(d); ignoreFs = ~d[0];
        runPair("R1 R3 R4 two-phase", 500 + lc * 10 + d);
      end
    end

    // R5: enable gaps carrying inverted junk on sdIn and fsIn
    for (int g = 1; g <= 2; g++) begin
      for (int d = 0; d < 3; d++) begin
        gapCycles = g; twoPhase = 1'b1; len1 = 3'(d); len2 = 3'(d + 2);
        cnt1 = 7'd1; cnt2 = 7'd0; dataDelay = 2'(d); ignoreFs = 1'b0;
        runPair("R5 gapped enable", 900 + g * 10 + d);
      end
    end
    gapCycles = 0;

    // R9: mid-frame edges ignored
    doReset();
    twoPhase = 1'b0; len1 = 3'd0; cnt1 = 7'd1; dataDelay = 2'd1; ignoreFs = 1'b1;
    clearStream(); addFrame(0, 90, 1'b1, n);
    fsArr[5] = 1'b1; fsArr[9] = 1'b1;
    tag = "R9 ignored edge"; autoRead = 1'b1;
    play(); repeat (8) @(negedge clk);
    check("R9 word count", expQ.size(), 0);
    check("R9 no sync error", {31'd0, syncErr}, 0);

    // R8: mid-frame edge restarts the frame and flags an error
    ignoreFs = 1'b0;
    clearStream(); addFrame(0, 91, 1'b0, n); addFrame(5, 92, 1'b1, n2);
    tag = "R8 restarted frame";
    play(); repeat (8) @(negedge clk);
    check("R8 word count", expQ.size(), 0);
    check("R8 sync error set", {31'd0, syncErr}, 1);

    // R7: overrun with the host idle
    autoRead = 1'b0; dataDelay = 2'd0; cnt1 = 7'd3;
    clearStream(); addFrame(0, 93, 1'b0, n);
    play(); repeat (3) @(negedge clk);
    check("R7 full set", {31'd0, full}, 1);
    check("R7 first word kept", rdData, elemVal(93, 0, 8));
    manRdS = 1'b1; @(negedge clk); manRdS = 1'b0;
    check("R7 read clears full", {31'd0, full}, 0);
    @(negedge clk);
    check("R7 buffered word follows", {31'd0, ready}, 1);
    check("R7 buffered word value", rdData, elemVal(93, 1, 8));
    manRdS = 1'b1; @(negedge clk); manRdS = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 overrun words discarded", {31'd0, ready}, 0);
    check("R8 sync error still held", {31'd0, syncErr}, 1);

    // R11: reset with words pending and full set
    cnt1 = 7'd2;
    clearStream(); addFrame(0, 94, 1'b0, n);
    play(); repeat (3) @(negedge clk);
    check("R7 full before reset", {31'd0, full}, 1);
    doReset();
    check("R11 ready cleared", {31'd0, ready}, 0);
    check("R11 full cleared", {31'd0, full}, 0);
    check("R11 syncErr cleared", {31'd0, syncErr}, 0);
    check("R11 rdData cleared", rdData, 0);
    repeat (3) @(negedge clk);
    check("R11 buffer emptied", {31'd0, ready}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule